// File: doc/BRIEF.md
# Ramped Stereo Gain Stage

This block scales a stream of 20-bit two's-complement stereo frames by a programmable linear level. The level runs from 0 (silence) to 1024 (unity). Software writes a target level together with a boost flag. The block never jumps to a new target. The applied level moves one code per stereo frame from wherever it currently is toward the most recent target, so gain changes are always gradual.

The boost flag changes the divisor from 1024 to 256. This adds +12.04 dB of gain. The result is rounded and clipped to the 20-bit range.

Two independent muting paths force zero data:
- **Direct mute:** a mute pin, sampled with each frame.
- **Post-reset mute:** a window that covers the first 3072 output words (1536 frames) after reset.

A frame strobe `in_vld` carries the left and right samples in parallel. The scaled frame appears on the outputs one clock later, with `out_vld` high for that one cycle.

Top module: `audio_gain_ramp`

## Requirements
- R1: A configuration write with a level of 1024 or more (0x400 to 0x7FF) stores a target of exactly 1024. Values 0 to 1023 are stored unchanged.
- R2: With boost low, each output equals round(sample × L / 1024). L is the level in force for that frame, and the rounding adds one half LSB and then takes the floor.
- R3: With boost high, each output equals round(sample × L / 256), using the same rounding. The result saturates to the range -524288 to 524287.
- R4: The applied level changes by exactly one code toward the stored target on each frame strobe, and by zero codes when it equals the target. A frame is scaled by the level held before its own step. Left and right always use the same level.
- R5: A new target written during a ramp takes effect from the current level, with no restart. The ramp reverses direction if the new target lies behind the current level.
- R6: A frame strobed while `mute_i` is high produces zero on both channels. The next frame strobed with `mute_i` low is scaled normally.
- R7: While `rst_n` is low, `out_vld` is 0 and both outputs are 0. Reset sets the level and the target to 1024 and clears the boost flag.
- R8: After reset, output words 1 to 3072 are zero. Each frame counts as two words, left and right. Word 3073, the left sample of frame 1537, is the first word scaled normally.
- R9: `out_vld` is high exactly in the cycle after each frame strobe. The outputs hold their values while no strobe arrives.
- R10: If a configuration write arrives in the same cycle as a frame strobe, that frame and its level step use the settings from before the write. The new target and boost apply from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Frame strobe; one stereo frame per high cycle |
| in_l | input | 20 | Left sample, two's complement |
| in_r | input | 20 | Right sample, two's complement |
| cfg_wr | input | 1 | Writes the target level and boost flag |
| cfg_level | input | 11 | Target level, linear units of 1/1024 |
| cfg_boost | input | 1 | 1 = divide by 256 (+12.04 dB) |
| mute_i | input | 1 | Direct mute, sampled with each frame |
| out_vld | output | 1 | Scaled frame valid |
| out_l | output | 20 | Scaled left sample |
| out_r | output | 20 | Scaled right sample |

## Verification
Two events can fall in the same cycle: a configuration write and a frame strobe. In that case the frame's scaling and its one-code level step must both still use the old target and boost. The bench provokes this by issuing a write together with a strobe, at a point where the old and new settings give different outputs both for that frame and for the next one. A reference model in the bench updates its target only after it has computed the frame and taken the step, and every output word is compared against that model. The bench also sweeps long ramps that reverse direction and that clip under boost.

// File: rtl/agr_pkg.sv
package agr_pkg;
  localparam int CHANNELS = 2;
  typedef enum logic [1:0] {RAMP_HOLD, RAMP_UP, RAMP_DOWN} ramp_dir_e;
endpackage

// File: rtl/agr_level_ramp.sv
module agr_level_ramp
  import agr_pkg::*;
#(
  parameter int LEVEL_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [LEVEL_W-1:0] cfg_level,
  input  logic               cfg_boost,
  input  logic               step_en,
  output logic [LEVEL_W-1:0] level_o,
  output logic               boost_o
);
  localparam logic [LEVEL_W-1:0] UNITY = LEVEL_W'(1) << (LEVEL_W - 1);

  logic [LEVEL_W-1:0] cur_q, cur_d, tgt_q, tgt_d;
  logic               boost_q, boost_d;
  ramp_dir_e          dir;

  always_comb begin
    tgt_d   = tgt_q;
    boost_d = boost_q;
    if (cfg_wr) begin
      tgt_d   = (cfg_level >= UNITY) ? UNITY : cfg_level;
      boost_d = cfg_boost;
    end
    if (cur_q < tgt_q)      dir = RAMP_UP;
    else if (cur_q > tgt_q) dir = RAMP_DOWN;
    else                    dir = RAMP_HOLD;
    cur_d = cur_q;
    if (step_en) begin
      case (dir)
        RAMP_UP:   cur_d = cur_q + 1'b1;
        RAMP_DOWN: cur_d = cur_q - 1'b1;
        default:   cur_d = cur_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= UNITY;
      tgt_q   <= UNITY;
      boost_q <= 1'b0;
    end else begin
      cur_q   <= cur_d;
      tgt_q   <= tgt_d;
      boost_q <= boost_d;
    end
  end

  assign level_o = cur_q;
  assign boost_o = boost_q;
endmodule

// File: rtl/agr_reset_mute.sv
module agr_reset_mute #(
  parameter int MUTE_WORDS      = 3072,
  parameter int WORDS_PER_FRAME = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_en,
  output logic active_o
);
  localparam int FRAMES = MUTE_WORDS / WORDS_PER_FRAME;
  localparam int CNT_W  = $clog2(FRAMES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active;

  always_comb begin
    active = (cnt_q < CNT_W'(FRAMES));
    cnt_d  = cnt_q;
    if (frame_en && active) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active_o = active;
endmodule

// File: rtl/agr_scaler.sv
module agr_scaler #(
  parameter int SAMPLE_W = 20,
  parameter int LEVEL_W  = 11
) (
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [LEVEL_W-1:0]  level_i,
  input  logic                       boost_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  localparam int PW       = SAMPLE_W + LEVEL_W + 1;
  localparam int SH_NORM  = LEVEL_W - 1;
  localparam int SH_BOOST = LEVEL_W - 3;
  localparam logic signed [PW-1:0] HALF_N = PW'(1) <<< (SH_NORM - 1);
  localparam logic signed [PW-1:0] HALF_B = PW'(1) <<< (SH_BOOST - 1);
  localparam logic signed [PW-1:0] SAT_HI = (PW'(1) <<< (SAMPLE_W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] SAT_LO = -SAT_HI - PW'(1);

  logic signed [PW-1:0] prod, biased, shifted;

  always_comb begin
    prod    = PW'(sample_i) * $signed({{(PW-LEVEL_W){1'b0}}, level_i});
    biased  = prod + (boost_i ? HALF_B : HALF_N);
    shifted = boost_i ? (biased >>> SH_BOOST) : (biased >>> SH_NORM);
    if (shifted > SAT_HI)      sample_o = SAT_HI[SAMPLE_W-1:0];
    else if (shifted < SAT_LO) sample_o = SAT_LO[SAMPLE_W-1:0];
    else                       sample_o = shifted[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/audio_gain_ramp.sv
module audio_gain_ramp
  import agr_pkg::*;
#(
  parameter int SAMPLE_W   = 20,
  parameter int LEVEL_W    = 11,
  parameter int MUTE_WORDS = 3072
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [SAMPLE_W-1:0] in_l,
  input  logic [SAMPLE_W-1:0] in_r,
  input  logic                cfg_wr,
  input  logic [LEVEL_W-1:0]  cfg_level,
  input  logic                cfg_boost,
  input  logic                mute_i,
  output logic                out_vld,
  output logic [SAMPLE_W-1:0] out_l,
  output logic [SAMPLE_W-1:0] out_r
);
  logic [1:0]          sync_q;
  logic                rst_q;
  logic [LEVEL_W-1:0]  level_w;
  logic                boost_w;
  logic                win_mute;
  logic                zero_frame;
  logic                vld_q;
  logic [SAMPLE_W-1:0] ch_in  [CHANNELS];
  logic [SAMPLE_W-1:0] ch_out [CHANNELS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_q = sync_q[1];

  agr_level_ramp #(.LEVEL_W(LEVEL_W)) ramp_i (
    .clk(clk), .rst_n(rst_q), .cfg_wr(cfg_wr), .cfg_level(cfg_level),
    .cfg_boost(cfg_boost), .step_en(in_vld), .level_o(level_w), .boost_o(boost_w)
  );

  agr_reset_mute #(.MUTE_WORDS(MUTE_WORDS), .WORDS_PER_FRAME(CHANNELS)) win_i (
    .clk(clk), .rst_n(rst_q), .frame_en(in_vld), .active_o(win_mute)
  );

  assign zero_frame = mute_i | win_mute;
  assign ch_in[0]   = in_l;
  assign ch_in[1]   = in_r;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    logic signed [SAMPLE_W-1:0] scaled;
    logic        [SAMPLE_W-1:0] data_q, data_d;

    agr_scaler #(.SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W)) scl_i (
      .sample_i($signed(ch_in[c])), .level_i(level_w), .boost_i(boost_w),
      .sample_o(scaled)
    );

    always_comb begin
      data_d = data_q;
      if (in_vld) data_d = zero_frame ? '0 : scaled;
    end

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) data_q <= '0;
      else        data_q <= data_d;
    end

    assign ch_out[c] = data_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) vld_q <= 1'b0;
    else        vld_q <= in_vld;
  end

  assign out_vld = vld_q;
  assign out_l   = ch_out[0];
  assign out_r   = ch_out[1];
endmodule

// File: rtl/agr_checker.sv
module agr_checker #(
  parameter int SAMPLE_W = 20,
  parameter int LEVEL_W  = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_vld,
  input logic                mute_i,
  input logic                win_mute,
  input logic [LEVEL_W-1:0]  lvl,
  input logic                out_vld,
  input logic [SAMPLE_W-1:0] out_l,
  input logic [SAMPLE_W-1:0] out_r
);
  localparam logic [LEVEL_W-1:0] UNITY = LEVEL_W'(1) << (LEVEL_W - 1);

  // R9
  out_vld_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(out_l) && $stable(out_r)));

  // R6
  direct_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && mute_i) |=> (out_l == '0 && out_r == '0));

  // R8
  reset_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && win_mute) |=> (out_l == '0 && out_r == '0));

  // R4
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (lvl == $past(lvl) || lvl == $past(lvl) + 1'b1 || lvl + 1'b1 == $past(lvl)));

  // R4
  level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(lvl));

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= UNITY);
endmodule

bind audio_gain_ramp agr_checker #(.SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W)) chk_i (
  .clk(clk), .rst_n(rst_q), .in_vld(in_vld), .mute_i(mute_i), .win_mute(win_mute),
  .lvl(level_w), .out_vld(out_vld), .out_l(out_l), .out_r(out_r)
);

// File: tb/audio_gain_ramp_tb.sv
module audio_gain_ramp_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [19:0] in_l = '0, in_r = '0;
  logic        cfg_wr = 1'b0;
  logic [10:0] cfg_level = '0;
  logic        cfg_boost = 1'b0;
  logic        mute_i = 1'b0;
  logic        out_vld;
  logic [19:0] out_l, out_r;

  int n_chk = 0, n_fail = 0;
  int lvl_m, tgt_m, fcnt_m;
  bit boost_m;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_gain_ramp dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_l(in_l), .in_r(in_r),
    .cfg_wr(cfg_wr), .cfg_level(cfg_level), .cfg_boost(cfg_boost), .mute_i(mute_i),
    .out_vld(out_vld), .out_l(out_l), .out_r(out_r)
  );

  function automatic int scl(int s, int lv, bit b);
    longint p, q;
    int sh;
    sh = b ? 8 : 10;
    p  = longint'(s) * longint'(lv);
    q  = (p + (64'sd1 <<< (sh - 1))) >>> sh;
    if (q > 524287)  q = 524287;
    if (q < -524288) q = -524288;
    return int'(q);
  endfunction

  task automatic chk(string tag, int gl, int gr, int el, int er);
    n_chk++;
    if (gl != el || gr != er) begin
      n_fail++;
      $display("FAIL %s: got L=%0d R=%0d expected L=%0d R=%0d", tag, gl, gr, el, er);
    end
  endtask

  task automatic model_reset();
    lvl_m = 1024; tgt_m = 1024; boost_m = 1'b0; fcnt_m = 0;
  endtask

  task automatic frame(int l, int r, bit m, bit w, int lev, bit bst, string tag);
    int el, er;
    bit z;
    @(negedge clk);
    in_vld = 1'b1; in_l = 20'(l); in_r = 20'(r); mute_i = m;
    cfg_wr = w; cfg_level = 11'(lev); cfg_boost = bst;
    z  = m || (fcnt_m < 1536);
    el = z ? 0 : scl(l, lvl_m, boost_m);
    er = z ? 0 : scl(r, lvl_m, boost_m);
    @(posedge clk);
    if (lvl_m < tgt_m) lvl_m++;
    else if (lvl_m > tgt_m) lvl_m--;
    fcnt_m++;
    if (w) begin
      tgt_m = (lev >= 1024) ? 1024 : lev;
      boost_m = bst;
    end
    @(negedge clk);
    in_vld = 1'b0; cfg_wr = 1'b0; mute_i = 1'b0;
    chk(tag, $signed(out_l), $signed(out_r), el, er);
    n_chk++;
    if (out_vld !== 1'b1) begin
      n_fail++;
      $display("FAIL R9: out_vld got %b expected 1", out_vld);
    end
  endtask

  task automatic cfg(int lev, bit bst);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_level = 11'(lev); cfg_boost = bst;
    @(posedge clk);
    tgt_m = (lev >= 1024) ? 1024 : lev;
    boost_m = bst;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  function automatic int patt(int i);
    return ((i * 7919 + 12345) % 1048576) - 524288;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 reset outputs", $signed(out_l), $signed(out_r), 0, 0);
    n_chk++;
    if (out_vld !== 1'b0) begin
      n_fail++;
      $display("FAIL R7: out_vld got %b expected 0", out_vld);
    end
    rst_n = 1'b1;
    model_reset();
    repeat (4) @(negedge clk);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    do_reset();
    // R8: post-reset window, data nonzero but output must be zero
    for (int i = 0; i < 1536; i++) frame(patt(i), -patt(i + 3), 1'b0, 1'b0, 0, 1'b0, "R8 window");
    // R8: word 3073 is first normal word; unity gain, extremes (R2)
    frame(524287, -524288, 1'b0, 1'b0, 0, 1'b0, "R8 first word");
    // R2 R4: ramp down to 0
    cfg(0, 1'b0);
    for (int i = 0; i < 1030; i++) frame(patt(i * 3), patt(i * 5 + 1), 1'b0, 1'b0, 0, 1'b0, "R4 ramp down");
    // R2 rounding small values at full mute and after
    frame(1, -1, 1'b0, 1'b0, 0, 1'b0, "R2 zero level");
    // R1: oversized target clamps to unity
    cfg(11'h7FF, 1'b0);
    for (int i = 0; i < 600; i++) frame(patt(i + 77), 511 - i, 1'b0, 1'b0, 0, 1'b0, "R1 ramp up");
    // R5: retarget mid ramp, reverse direction
    cfg(11'h100, 1'b0);
    for (int i = 0; i < 400; i++) frame(patt(i + 9), -patt(i), 1'b0, 1'b0, 0, 1'b0, "R5 reverse");
    cfg(11'h500, 1'b0);
    for (int i = 0; i < 770; i++) frame(patt(i * 11), i * 3 - 1000, 1'b0, 1'b0, 0, 1'b0, "R1 R5 up");
    // R3: boost at unity level saturates
    cfg(11'h400, 1'b1);
    frame(200000, -300000, 1'b0, 1'b0, 0, 1'b0, "R3 saturate");
    frame(1000, -131072, 1'b0, 1'b0, 0, 1'b0, "R3 times four");
    cfg(11'h100, 1'b1);
    for (int i = 0; i < 770; i++) frame(patt(i * 13 + 5), patt(i + 2) / 8, 1'b0, 1'b0, 0, 1'b0, "R3 ramp boost");
    // R6: direct mute one frame then resume
    frame(123456, -654, 1'b1, 1'b0, 0, 1'b0, "R6 mute on");
    frame(123456, -654, 1'b0, 1'b0, 0, 1'b0, "R6 mute off");
    // R10: write coincides with frame; level 256 boost vs level 0 normal
    frame(40000, -40000, 1'b0, 1'b1, 0, 1'b0, "R10 same cycle");
    frame(40000, -40000, 1'b0, 1'b0, 0, 1'b0, "R10 next frame");
    // R9: outputs hold while idle
    begin
      logic [19:0] hl, hr;
      hl = out_l; hr = out_r;
      repeat (3) @(negedge clk);
      chk("R9 hold", $signed(out_l), $signed(out_r), $signed(hl), $signed(hr));
      n_chk++;
      if (out_vld !== 1'b0) begin
        n_fail++;
        $display("FAIL R9: idle out_vld got %b expected 0", out_vld);
      end
    end
    // R7: reset restores unity level and clears boost
    cfg(11'h080, 1'b1);
    for (int i = 0; i < 10; i++) frame(patt(i), patt(i + 1), 1'b0, 1'b0, 0, 1'b0, "R3 pre reset");
    do_reset();
    for (int i = 0; i < 1536; i++) frame(300000, -300000, 1'b0, 1'b0, 0, 1'b0, "R8 window again");
    frame(300000, -300000, 1'b0, 1'b0, 0, 1'b0, "R7 unity after reset");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule